// File: doc/BRIEF.md
# Pipeline Interlock and Redirect Control

This block is the hazard and control-flow controller for a five-stage in-order integer pipeline with the stages fetch, decode, execute, memory and writeback. It has no bypass network, so every read-after-write conflict is resolved by an interlock. Each cycle it compares the two decode-stage source specifiers against the destinations of the three older in-flight instructions. From that it decides whether decode must wait.

It also resolves control flow. Jumps are detected in decode. Conditional branches on the zero flag are resolved in execute. The block picks the next-PC source and tells the datapath which instruction registers must be overwritten with a no-op. An older redirect in execute always wins over a younger one in decode. A taken branch also cancels any stall, because the instruction waiting in decode is on the wrong path.

The block is purely combinational. The datapath owns the PC, the instruction registers and their muxes, and feeds back the opcodes, the specifiers and the zero flag.

Top module: `hazard_ctrl`

## Requirements
- R1: `stall` is 1 when a decode source with its read enable set equals the destination of the execute, memory or writeback instruction whose write enable is set. Both source A and source B are compared against all three stages.
- R2: A destination specifier of 0 never produces a match, because register 0 always reads as zero.
- R3: A conditional branch in execute is taken when its opcode is BEQZ (6'd4) and `ex_zero`=1, or when its opcode is BNEZ (6'd5) and `ex_zero`=0. A taken branch forces `stall` to 0.
- R4: `pc_sel` encodes the next-PC source: 0 = PC+4, 1 = absolute jump target, 2 = register-indirect target, 3 = branch target. A taken branch in execute gives 3, and this has the highest priority.
- R5: When no branch is taken and `stall`=0, a decode opcode of J (6'd2) or JAL (6'd3) gives `pc_sel`=1, and a decode opcode of JR (6'd8) or JALR (6'd9) gives `pc_sel`=2. Any other case gives 0.
- R6: `dec_sel` selects what the decode instruction register loads: 0 = the fetched instruction, 1 = a no-op, 2 = hold its current value. A taken branch gives 1. Otherwise `stall` gives 2. Otherwise any jump in decode gives 1. Otherwise the value is 0.
- R7: `ex_nop`=1 loads a no-op into the execute instruction register, and `ex_nop`=0 passes the decode instruction on. It is 1 exactly when a branch is taken or `stall`=1.
- R8: A jump in decode that is stalled does not redirect. `pc_sel` stays 0 so that the PC holds, and the jump is acted on once the stall clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | RW | Decode-stage source A specifier |
| dec_src_b | input | RW | Decode-stage source B specifier |
| dec_rd_a | input | 1 | Source A is read |
| dec_rd_b | input | 1 | Source B is read |
| ex_dst | input | RW | Execute-stage destination |
| ex_wen | input | 1 | Execute-stage instruction writes |
| mem_dst | input | RW | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage instruction writes |
| wb_dst | input | RW | Writeback-stage destination |
| wb_wen | input | 1 | Writeback-stage instruction writes |
| dec_op | input | OPW | Decode-stage opcode |
| ex_op | input | OPW | Execute-stage opcode |
| ex_zero | input | 1 | Execute-stage operand is zero |
| stall | output | 1 | Interlock: hold fetch and decode, bubble execute |
| pc_sel | output | 2 | Next-PC source select |
| dec_sel | output | 2 | Decode instruction-register select |
| ex_nop | output | 1 | Execute instruction register takes a no-op |

## Verification
The bench targets hazards against each of the three older stages and on each source port. A design that missed a stage or a port would let a stale operand through with `stall` low. Register 0 destinations and cleared enables are driven to catch false interlocks, which would show up as a stuck `stall`. A hazard coinciding with a taken branch is driven to catch a design that stalls on a wrong-path instruction and deadlocks the redirect. A branch with a jump behind it, and a jump under a stall, are driven to catch inverted priority, which would steer the PC to the younger target.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int RW = 5,
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_J    = 6'd2,
  parameter logic [OPW-1:0] OP_JAL  = 6'd3,
  parameter logic [OPW-1:0] OP_BEQZ = 6'd4,
  parameter logic [OPW-1:0] OP_BNEZ = 6'd5,
  parameter logic [OPW-1:0] OP_JR   = 6'd8,
  parameter logic [OPW-1:0] OP_JALR = 6'd9
) (
  input  logic [RW-1:0]  dec_src_a,
  input  logic [RW-1:0]  dec_src_b,
  input  logic           dec_rd_a,
  input  logic           dec_rd_b,
  input  logic [RW-1:0]  ex_dst,
  input  logic           ex_wen,
  input  logic [RW-1:0]  mem_dst,
  input  logic           mem_wen,
  input  logic [RW-1:0]  wb_dst,
  input  logic           wb_wen,
  input  logic [OPW-1:0] dec_op,
  input  logic [OPW-1:0] ex_op,
  input  logic           ex_zero,
  output logic           stall,
  output logic [1:0]     pc_sel,
  output logic [1:0]     dec_sel,
  output logic           ex_nop
);
  localparam logic [1:0] PC_SEQ = 2'd0, PC_ABS = 2'd1, PC_IND = 2'd2, PC_BR = 2'd3;
  localparam logic [1:0] DS_FETCH = 2'd0, DS_NOP = 2'd1, DS_HOLD = 2'd2;

  // a destination only counts when it writes and is not register 0
  function automatic logic busy(input logic [RW-1:0] src, input logic [RW-1:0] dst,
                                input logic wen);
    return wen && (dst != '0) && (dst == src);
  endfunction

  logic hz_a, hz_b, br_taken, jmp_abs, jmp_ind;

  assign hz_a = dec_rd_a && (busy(dec_src_a, ex_dst, ex_wen) ||
                             busy(dec_src_a, mem_dst, mem_wen) ||
                             busy(dec_src_a, wb_dst, wb_wen));
  assign hz_b = dec_rd_b && (busy(dec_src_b, ex_dst, ex_wen) ||
                             busy(dec_src_b, mem_dst, mem_wen) ||
                             busy(dec_src_b, wb_dst, wb_wen));

  assign br_taken = ((ex_op == OP_BEQZ) && ex_zero) || ((ex_op == OP_BNEZ) && !ex_zero);
  assign stall    = (hz_a || hz_b) && !br_taken;

  assign jmp_abs = (dec_op == OP_J)  || (dec_op == OP_JAL);
  assign jmp_ind = (dec_op == OP_JR) || (dec_op == OP_JALR);

  always_comb begin
    if (br_taken)                pc_sel = PC_BR;
    else if (stall)              pc_sel = PC_SEQ;
    else if (jmp_abs)            pc_sel = PC_ABS;
    else if (jmp_ind)            pc_sel = PC_IND;
    else                         pc_sel = PC_SEQ;
  end

  always_comb begin
    if (br_taken)                dec_sel = DS_NOP;
    else if (stall)              dec_sel = DS_HOLD;
    else if (jmp_abs || jmp_ind) dec_sel = DS_NOP;
    else                         dec_sel = DS_FETCH;
  end

  assign ex_nop = br_taken || stall;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int RW = 5
) (
  input logic [RW-1:0] ex_dst,
  input logic [RW-1:0] mem_dst,
  input logic [RW-1:0] wb_dst,
  input logic          stall,
  input logic [1:0]    pc_sel,
  input logic [1:0]    dec_sel,
  input logic          ex_nop
);
  always_comb begin
    AST_BR_NO_STALL: assert (!(pc_sel == 2'd3 && stall));                      // R3
    AST_BR_KILLS_TWO: assert (pc_sel != 2'd3 || (dec_sel == 2'd1 && ex_nop));  // R4
    AST_STALL_HOLDS: assert (!stall || (pc_sel == 2'd0 && dec_sel == 2'd2));   // R8
    AST_STALL_BUBBLE: assert (!stall || ex_nop);                               // R7
    AST_JUMP_KILLS_ONE: assert (!(pc_sel == 2'd1 || pc_sel == 2'd2) ||
                                (dec_sel == 2'd1 && !ex_nop));                  // R6
    AST_R0_NO_HAZARD: assert (!(ex_dst == '0 && mem_dst == '0 && wb_dst == '0) ||
                              !stall);                                          // R2
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.RW(RW)) chk_i (
  .ex_dst(ex_dst), .mem_dst(mem_dst), .wb_dst(wb_dst),
  .stall(stall), .pc_sel(pc_sel), .dec_sel(dec_sel), .ex_nop(ex_nop)
);

// File: tb/hazard_ctrl_tb_top.sv
module hazard_ctrl_tb_top;
  logic clk = 0;
  always #2 clk = ~clk;

  logic [4:0] src_a, src_b, exd, memd, wbd;
  logic rda, rdb, exw, memw, wbw, zero;
  logic [5:0] dop, eop;
  logic stall, ex_nop;
  logic [1:0] pc_sel, dec_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  hazard_ctrl dut_i (
    .dec_src_a(src_a), .dec_src_b(src_b), .dec_rd_a(rda), .dec_rd_b(rdb),
    .ex_dst(exd), .ex_wen(exw), .mem_dst(memd), .mem_wen(memw),
    .wb_dst(wbd), .wb_wen(wbw), .dec_op(dop), .ex_op(eop), .ex_zero(zero),
    .stall(stall), .pc_sel(pc_sel), .dec_sel(dec_sel), .ex_nop(ex_nop)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    src_a = 0; src_b = 0; rda = 0; rdb = 0; exd = 0; memd = 0; wbd = 0;
    exw = 0; memw = 0; wbw = 0; dop = 6'd0; eop = 6'd0; zero = 0;
  endtask

  task automatic expect_all(input string req, input int s, input int p, input int d, input int e);
    #1;
    chk({req, " stall"}, stall, s);
    chk({req, " pc_sel"}, pc_sel, p);
    chk({req, " dec_sel"}, dec_sel, d);
    chk({req, " ex_nop"}, ex_nop, e);
  endtask

  task automatic t_idle();
    idle(); expect_all("R5 idle", 0, 0, 0, 0);
  endtask

  task automatic t_load_use();
    idle(); src_a = 5'd7; rda = 1; exd = 5'd7; exw = 1;
    expect_all("R1 ex on A", 1, 0, 2, 1);
    idle(); src_b = 5'd3; rdb = 1; memd = 5'd3; memw = 1;
    expect_all("R1 mem on B", 1, 0, 2, 1);
    idle(); src_a = 5'd12; rda = 1; wbd = 5'd12; wbw = 1;
    expect_all("R1 wb on A", 1, 0, 2, 1);
    idle(); src_a = 5'd7; rda = 0; exd = 5'd7; exw = 1;
    expect_all("R1 read enable off", 0, 0, 0, 0);
    idle(); src_a = 5'd7; rda = 1; exd = 5'd7; exw = 0;
    expect_all("R1 write enable off", 0, 0, 0, 0);
    idle(); src_a = 5'd7; rda = 1; exd = 5'd8; exw = 1;
    expect_all("R1 mismatch", 0, 0, 0, 0);
  endtask

  task automatic t_r0();
    idle(); src_a = 0; src_b = 0; rda = 1; rdb = 1;
    exw = 1; memw = 1; wbw = 1;
    expect_all("R2 r0 dest", 0, 0, 0, 0);
  endtask

  task automatic t_jumps();
    idle(); dop = 6'd2; expect_all("R5 J", 0, 1, 1, 0);
    idle(); dop = 6'd3; expect_all("R5 JAL", 0, 1, 1, 0);
    idle(); dop = 6'd8; expect_all("R5 JR", 0, 2, 1, 0);
    idle(); dop = 6'd9; expect_all("R5 JALR", 0, 2, 1, 0);
  endtask

  task automatic t_branches();
    idle(); eop = 6'd4; zero = 1; expect_all("R4 BEQZ taken", 0, 3, 1, 1);
    idle(); eop = 6'd4; zero = 0; expect_all("R3 BEQZ not taken", 0, 0, 0, 0);
    idle(); eop = 6'd5; zero = 0; expect_all("R4 BNEZ taken", 0, 3, 1, 1);
    idle(); eop = 6'd5; zero = 1; expect_all("R3 BNEZ not taken", 0, 0, 0, 0);
  endtask

  task automatic t_hazard_and_branch();
    idle(); eop = 6'd4; zero = 1; src_a = 5'd9; rda = 1; memd = 5'd9; memw = 1;
    expect_all("R3 hazard under taken branch", 0, 3, 1, 1);
    idle(); eop = 6'd5; zero = 1; src_b = 5'd9; rdb = 1; exd = 5'd9; exw = 1;
    expect_all("R7 hazard under untaken branch", 1, 0, 2, 1);
  endtask

  task automatic t_priority();
    idle(); eop = 6'd5; zero = 0; dop = 6'd8;
    expect_all("R6 branch over jump", 0, 3, 1, 1);
    idle(); dop = 6'd8; src_a = 5'd4; rda = 1; exd = 5'd4; exw = 1;
    expect_all("R8 stalled jump holds", 1, 0, 2, 1);
  endtask

  initial begin
    idle();
    t_idle();
    t_load_use();
    t_r0();
    t_jumps();
    t_branches();
    t_hazard_and_branch();
    t_priority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule